// File: doc/BRIEF.md
# Configuration Register Bank

A single-clock bank of byte-wide storage locations, written and read by a controller through a shared address, a write strobe and a read strobe. A read is registered: the addressed byte appears on the read port one clock after the request, marked by a read-valid flag that is high for exactly one cycle.

The four lowest locations are reserved. Their contents are driven out continuously on dedicated outputs. Location 0 and location 1 supply the two arithmetic operands. Location 2 supplies the serial-link settings: parity on/off, parity sense and a six-bit oversampling prescale. Location 3 supplies a clock-divide ratio. Locations 2 and 3 come out of reset with nonzero defaults, so the serial link and the divider work before any write is made. The consumers of these outputs are not part of this block.

Top module: `cfg_regbank`

## Requirements
- R1: On a rising clock edge with `wr_en` high, `wr_data` is stored in the location selected by `addr`. There are 16 locations of 8 bits each.
- R2: On a rising clock edge with `rd_en` high and `wr_en` low, the byte held at `addr` appears on `rd_data` after that edge, and `rd_valid` is high for that one cycle.
- R3: `rd_valid` is low in every cycle that does not follow an accepted read. `rd_data` keeps its last value until the next accepted read.
- R4: When `wr_en` and `rd_en` are both high at the same edge, the write is performed and the read is dropped: `rd_valid` stays low and `rd_data` does not change.
- R5: `opnd_a` always equals location 0 and `opnd_b` always equals location 1, updated in the cycle after a write to them.
- R6: Location 2 drives `par_en` from bit 0, `par_odd` from bit 1 and `prescale` from bits 7..2. Its reset value is 0x81: parity on, even sense, prescale 32.
- R7: Location 3 drives `div_ratio` on all 8 bits. Its reset value is 0x20.
- R8: `rst_n` is an asynchronous active-low reset. It loads every location other than 2 and 3 with zero, clears `rd_data` and `rd_valid` at once without a clock edge, and is released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Location select, shared by read and write |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | One-cycle flag marking a new `rd_data` |
| opnd_a | output | 8 | Contents of location 0 |
| opnd_b | output | 8 | Contents of location 1 |
| par_en | output | 1 | Location 2 bit 0 |
| par_odd | output | 1 | Location 2 bit 1 |
| prescale | output | 6 | Location 2 bits 7..2 |
| div_ratio | output | 8 | Contents of location 3 |

## Verification
A write and a read can be requested at the same edge. The bench provokes this in directed cases on a reserved location and on a general one, and often in the random phase, where both strobes are drawn independently. Each collision is judged at the next falling edge. The written byte must appear on the dedicated outputs or in a later read-back. `rd_valid` must stay low, and `rd_data` must still hold the value of the previous accepted read.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int RB_DW        = 8;
  localparam int RB_PRESC_LSB = 2;
  localparam int RB_PRESC_W   = RB_DW - RB_PRESC_LSB;
  localparam int RB_LOC_OPA   = 0;
  localparam int RB_LOC_OPB   = 1;
  localparam int RB_LOC_LINK  = 2;
  localparam int RB_LOC_DIV   = 3;
  localparam int RB_RESERVED  = 4;

  localparam logic            DFLT_PAR_EN  = 1'b1;
  localparam logic            DFLT_PAR_ODD = 1'b0;
  localparam int              DFLT_PRESC   = 32;
  localparam int              DFLT_DIV     = 32;

  typedef logic [RB_DW-1:0] rb_word_t;

  function automatic rb_word_t link_word(input int presc, input logic odd, input logic en);
    rb_word_t w;
    w = rb_word_t'(presc) << RB_PRESC_LSB;
    w[1] = odd;
    w[0] = en;
    return w;
  endfunction

  function automatic rb_word_t loc_default(input int idx);
    case (idx)
      RB_LOC_LINK: return link_word(DFLT_PRESC, DFLT_PAR_ODD, DFLT_PAR_EN);
      RB_LOC_DIV:  return rb_word_t'(DFLT_DIV);
      default:     return '0;
    endcase
  endfunction
endpackage

// File: rtl/regbank_store.sv
module regbank_store
  import cfg_regbank_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [ADDR_W-1:0]           wr_idx,
  input  rb_word_t                    wr_word,
  output logic [DEPTH-1:0][RB_DW-1:0] words_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    localparam rb_word_t RST_VAL = loc_default(i);
    logic hit;
    assign hit = wr_fire && (wr_idx == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words_o[i] <= RST_VAL;
      else if (hit) words_o[i] <= wr_word;
    end
  end

  // R1
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> words_o[$past(wr_idx)] == $past(wr_word));

  // R1
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(words_o));
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport
  import cfg_regbank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_fire,
  input  rb_word_t rd_word,
  output rb_word_t rd_data,
  output logic     rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_word;
    end
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid && (rd_data == $past(rd_word)));

  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid && $stable(rd_data));
endmodule

// File: rtl/regbank_cfgtap.sv
module regbank_cfgtap
  import cfg_regbank_pkg::*;
(
  input  rb_word_t                  w_opa,
  input  rb_word_t                  w_opb,
  input  rb_word_t                  w_link,
  input  rb_word_t                  w_div,
  output rb_word_t                  opnd_a,
  output rb_word_t                  opnd_b,
  output logic                      par_en,
  output logic                      par_odd,
  output logic [RB_PRESC_W-1:0]     prescale,
  output rb_word_t                  div_ratio
);
  assign opnd_a    = w_opa;
  assign opnd_b    = w_opb;
  assign par_en    = w_link[0];
  assign par_odd   = w_link[1];
  assign prescale  = w_link[RB_DW-1:RB_PRESC_LSB];
  assign div_ratio = w_div;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [$clog2(DEPTH)-1:0]  addr,
  input  logic [RB_DW-1:0]          wr_data,
  output logic [RB_DW-1:0]          rd_data,
  output logic                      rd_valid,
  output logic [RB_DW-1:0]          opnd_a,
  output logic [RB_DW-1:0]          opnd_b,
  output logic                      par_en,
  output logic                      par_odd,
  output logic [RB_PRESC_W-1:0]     prescale,
  output logic [RB_DW-1:0]          div_ratio
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic                        wr_fire;
  logic                        rd_fire;
  logic                        rw_clash;
  logic [DEPTH-1:0][RB_DW-1:0] words;

  assign wr_fire  = wr_en;
  assign rd_fire  = rd_en && !wr_en;
  assign rw_clash = wr_en && rd_en;

  regbank_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(addr),
    .wr_word(wr_data), .words_o(words)
  );

  regbank_rdport u_rd (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_word(words[addr]),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  regbank_cfgtap u_tap (
    .w_opa(words[RB_LOC_OPA]), .w_opb(words[RB_LOC_OPB]),
    .w_link(words[RB_LOC_LINK]), .w_div(words[RB_LOC_DIV]),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .par_en(par_en), .par_odd(par_odd),
    .prescale(prescale), .div_ratio(div_ratio)
  );

  // R4
  clash_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_clash |=> !rd_valid && $stable(rd_data));

  // R5
  opa_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(RB_LOC_OPA)) |=> opnd_a == $past(wr_data));

  // R7
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(RB_LOC_DIV)) |=> div_ratio == $past(wr_data));

  // R6
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(RB_LOC_LINK)) |=> $stable({prescale, par_odd, par_en}));
endmodule

// File: tb/sim_cfg_regbank.sv
module sim_cfg_regbank;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wr_data, rd_data, opnd_a, opnd_b, div_ratio;
  logic       rd_valid, par_en, par_odd;
  logic [5:0] prescale;

  cfg_regbank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .par_en(par_en), .par_odd(par_odd),
    .prescale(prescale), .div_ratio(div_ratio)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] model [16];
  logic [7:0] exp_rd;
  logic       exp_v;
  bit         done = 0;

  function automatic logic [7:0] dflt(input int a);
    if (a == 2) return 8'd1 | (8'd32 * 8'd4);
    if (a == 3) return 8'd32;
    return 8'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
    exp_rd = 8'h00;
    exp_v  = 1'b0;
  endtask

  task automatic check_all();
    chk("R3 rd_valid", 32'(rd_valid), 32'(exp_v));
    chk("R2 rd_data", 32'(rd_data), 32'(exp_rd));
    chk("R5 opnd_a", 32'(opnd_a), 32'(model[0]));
    chk("R5 opnd_b", 32'(opnd_b), 32'(model[1]));
    chk("R6 par_en", 32'(par_en), 32'(model[2] % 2));
    chk("R6 par_odd", 32'(par_odd), 32'((model[2] / 2) % 2));
    chk("R6 prescale", 32'(prescale), 32'(model[2] / 4));
    chk("R7 div_ratio", 32'(div_ratio), 32'(model[3]));
  endtask

  // drive at a falling edge, predict, sample at the next falling edge
  task automatic step(input bit w, input bit r, input int a, input logic [7:0] d);
    wr_en = w; rd_en = r; addr = 4'(a); wr_data = d;
    if (w) begin
      model[a] = d;
      exp_v = 1'b0;
    end else if (r) begin
      exp_rd = model[a];
      exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
    end
    @(negedge clk);
    check_all();
    if (w && r) chk("R4 clash rd_valid", 32'(rd_valid), 32'd0);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    model_reset();
    #20;
    // R8 reset state, R6/R7 defaults
    check_all();
    chk("R6 reset par_en", 32'(par_en), 32'd1);
    chk("R6 reset prescale", 32'(prescale), 32'd32);
    chk("R7 reset div", 32'(div_ratio), 32'h20);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R8 read back all defaults
    for (int i = 0; i < 16; i++) begin
      step(0, 1, i, 8'h00);
      chk("R8 default read", 32'(rd_data), 32'(dflt(i)));
    end
    step(0, 0, 0, 8'h00);  // R3 valid drops, data holds

    // R1 write then immediate read back
    step(1, 0, 9, 8'h5A);
    step(0, 1, 9, 8'h00);
    chk("R1 read-after-write", 32'(rd_data), 32'h5A);
    // R6 link word fields
    step(1, 0, 2, 8'hFE);
    chk("R6 prescale all ones", 32'(prescale), 32'd63);
    chk("R6 par_en cleared", 32'(par_en), 32'd0);
    // R4 collisions on reserved and general locations
    step(0, 1, 7, 8'h00);
    step(1, 1, 3, 8'hC3);
    chk("R4 data kept", 32'(rd_data), 32'(model[7]));
    step(1, 1, 12, 8'h99);
    step(0, 1, 12, 8'h00);
    chk("R4 write landed", 32'(rd_data), 32'h99);

    // random mix
    for (int k = 0; k < 600; k++) begin
      step(bit'($urandom % 3 == 0), bit'($urandom % 2), int'($urandom % 16), 8'($urandom));
      if (k % 4 == 0) step(0, 0, 0, 8'h00);
    end

    // R8 asynchronous reset between edges
    #2 rst_n = 0;
    #1;
    model_reset();
    check_all();
    @(negedge clk); rst_n = 1;
    step(0, 1, 5, 8'h00);
    chk("R8 post-reset zero", 32'(rd_data), 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule